// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block collects interrupt requests from fifteen sources and folds them onto ten vectors. A vector may be fed by one source or by several. Each vector gets one of three priority tiers: top, high or low. Only the first two vectors can reach the top tier; every other vector chooses between high and low. On every cycle the arbiter picks one vector among those with a live request. It prefers the higher tier and breaks ties by the lower vector address. It hands the vector to the processor only if its tier is strictly above the tier of the handler now running.

A small in-service record keeps the tiers of nested handlers. The processor pulses an end-of-handler strobe when a handler returns, and that pops the newest entry. When a vector is issued, the block raises a one-cycle interrupt pulse together with the vector address. In the same cycle it sends a one-hot acknowledge to the source being served, and that source's pending flag is cleared.

Top module: `irq3_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `src_ack_o` is all zeros, `vec_addr_o` is 0 and no handler is recorded as in service.
- R2: Source s feeds vector s for s below 10. Sources 10 and 11 feed vector 3, sources 12 and 13 feed vector 6, and source 14 feeds vector 7. The address issued for vector index v is 0x03 + 8*v, so the addresses run from 0x03 to 0x4B.
- R3: The tier of a vector is set by `lvl_hi_i[v]`. A 0 gives low. A 1 gives top for vectors 0 and 1, and high for vectors 2 to 9. The tiers rank top > high > low.
- R4: Among live vectors the highest tier wins. Among live vectors of the same tier, the lowest index (lowest address) wins.
- R5: While a handler is in service, a live vector of the same or a lower tier is not issued. A vector of a strictly higher tier is issued and nests.
- R6: A shared vector is live when any of its enabled sources is pending. The acknowledge goes to the lowest-numbered pending enabled source of that vector. Its sibling stays pending and is issued later.
- R7: A request sampled at one clock edge is issued as `irq_o`, `vec_addr_o` and a one-hot `src_ack_o`, all in the cycle after the next edge. `irq_o` and `src_ack_o` last exactly one cycle.
- R8: A pending request that loses or is held off stays pending until it is served. Clearing its enable for one cycle discards it. A request raised while its enable is 0 is ignored.
- R9: `eoh_i` removes the most recently entered tier from the in-service record. Nothing is issued in a cycle where `eoh_i` is 1. A vector held off by the removed tier is issued two edges after `eoh_i` is sampled.
- R10: The record holds three nested tiers. Once a top-tier handler is in service, another top-tier request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 15 | Request pulse per source |
| src_en_i | input | 15 | Enable per source |
| lvl_hi_i | input | 10 | Tier select per vector (1 = upper tier) |
| eoh_i | input | 1 | End-of-handler strobe |
| irq_o | output | 1 | One-cycle interrupt pulse to the processor |
| vec_addr_o | output | 8 | Address of the issued vector |
| src_ack_o | output | 15 | One-hot acknowledge to the served source |

## Verification
A fault in the in-service record shows up at the ports as a nesting decision made against the wrong tier. For example, a request of equal tier could pulse `irq_o` while it should wait, or a valid higher-tier request could stay silent. This is visible at most two edges after the request or the end-of-handler strobe. A fault in the pending flags shows up as a missing or repeated vector after the blocking handler ends. A fault in the tie-breaking shows up at once in `vec_addr_o` and in which `src_ack_o` bit is set.

// File: rtl/irq3_pkg.sv
package irq3_pkg;

   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_LOW  = 2'd1,
      LVL_HIGH = 2'd2,
      LVL_TOP  = 2'd3
   } irq_lvl_e;

   // Number of sharing slots in the fold pattern used for surplus sources.
   localparam int unsigned FOLD_SLOTS = 5;

   // Vector fed by source s: one-to-one for the first n_vec sources,
   // surplus sources fold onto vectors 3, 3, 6, 6, 7 (repeating).
   function automatic int unsigned vec_of_src(int unsigned s, int unsigned n_vec);
      int unsigned k;
      if (s < n_vec) return s;
      k = (s - n_vec) % FOLD_SLOTS;
      case (k)
         0, 1:    return 3 % n_vec;
         2, 3:    return 6 % n_vec;
         default: return 7 % n_vec;
      endcase
   endfunction

endpackage

// File: rtl/irq3_pend.sv
module irq3_pend #(
   parameter int N_SRC = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_SRC-1:0] src_en,
   input  logic [N_SRC-1:0] src_clr,
   output logic [N_SRC-1:0] pend_o
);

   logic [N_SRC-1:0] pend_q;

   generate
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[s] <= 1'b0;
            else        pend_q[s] <= src_en[s] & ((pend_q[s] & ~src_clr[s]) | src_req[s]);
         end
      end
   endgenerate

   assign pend_o = pend_q;

   // R8: a source disabled in one cycle holds no pending flag in the next
   p_drop_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(src_en)) == '0));

   // R8: an enabled request is always captured
   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_req & src_en) != '0) |=> ((pend_q & $past(src_req & src_en)) == $past(src_req & src_en)));

endmodule

// File: rtl/irq3_vec_merge.sv
module irq3_vec_merge
   import irq3_pkg::*;
#(
   parameter int N_SRC    = 15,
   parameter int N_VEC    = 10,
   parameter int N_TOPCAP = 2
) (
   input  logic [N_SRC-1:0]      src_live,
   input  logic [N_VEC-1:0]      lvl_hi,
   output logic [N_VEC-1:0]      vec_pend,
   output logic [N_VEC-1:0][1:0] vec_lvl
);

   function automatic logic [N_SRC-1:0] member_mask(int unsigned v);
      logic [N_SRC-1:0] m;
      m = '0;
      for (int s = 0; s < N_SRC; s++)
         m[s] = (vec_of_src(s, N_VEC) == v);
      return m;
   endfunction

   generate
      for (genvar v = 0; v < N_VEC; v++) begin : g_vec
         localparam logic [N_SRC-1:0] MEMB = member_mask(v);
         assign vec_pend[v] = |(src_live & MEMB);
         if (v < N_TOPCAP) begin : g_topcap
            assign vec_lvl[v] = lvl_hi[v] ? LVL_TOP : LVL_LOW;
         end else begin : g_highcap
            assign vec_lvl[v] = lvl_hi[v] ? LVL_HIGH : LVL_LOW;
         end
      end
   endgenerate

endmodule

// File: rtl/irq3_arb.sv
module irq3_arb
   import irq3_pkg::*;
#(
   parameter int N_SRC = 15,
   parameter int N_VEC = 10,
   parameter int VIW   = $clog2(N_VEC)
) (
   input  logic [N_VEC-1:0]      vec_pend,
   input  logic [N_VEC-1:0][1:0] vec_lvl,
   input  logic [N_SRC-1:0]      src_live,
   output logic                  win_valid,
   output logic [1:0]            win_lvl,
   output logic [VIW-1:0]        win_idx,
   output logic [N_SRC-1:0]      win_src_oh
);

   // Descending scan with >= keeps the lowest index among equal tiers.
   always_comb begin
      win_lvl = LVL_NONE;
      win_idx = '0;
      for (int v = N_VEC - 1; v >= 0; v--) begin
         if (vec_pend[v] && (vec_lvl[v] >= win_lvl)) begin
            win_lvl = vec_lvl[v];
            win_idx = VIW'(v);
         end
      end
      win_valid = (win_lvl != LVL_NONE);
   end

   // Lowest-numbered live source that belongs to the winning vector.
   always_comb begin
      win_src_oh = '0;
      for (int s = N_SRC - 1; s >= 0; s--) begin
         if (win_valid && src_live[s] && (VIW'(vec_of_src(s, N_VEC)) == win_idx)) begin
            win_src_oh    = '0;
            win_src_oh[s] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irq3_isr_rec.sv
module irq3_isr_rec
   import irq3_pkg::*;
#(
   parameter int DEPTH = 3,
   parameter int STYLE = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic [1:0] push_lvl,
   input  logic       pop,
   output logic [1:0] top_lvl,
   output logic       full
);

   generate
      if (STYLE == 0) begin : g_mask
         if (DEPTH != 3) begin : g_bad_depth
            $error("irq3_isr_rec: mask style needs DEPTH of 3");
         end
         logic [2:0] msk_q;

         always_comb begin
            if (msk_q[2])      top_lvl = LVL_TOP;
            else if (msk_q[1]) top_lvl = LVL_HIGH;
            else if (msk_q[0]) top_lvl = LVL_LOW;
            else               top_lvl = LVL_NONE;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               msk_q <= '0;
            end else if (push) begin
               msk_q[push_lvl - 2'd1] <= 1'b1;
            end else if (pop && top_lvl != LVL_NONE) begin
               msk_q[top_lvl - 2'd1] <= 1'b0;
            end
         end

         assign full = msk_q[2];
      end else begin : g_stack
         localparam int CW = $clog2(DEPTH + 1);
         logic [DEPTH-1:0][1:0] stk_q;
         logic [CW-1:0]         cnt_q;

         always_comb begin
            top_lvl = LVL_NONE;
            for (int i = 0; i < DEPTH; i++)
               if (CW'(i) < cnt_q) top_lvl = stk_q[i];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stk_q <= '0;
               cnt_q <= '0;
            end else if (push && cnt_q != CW'(DEPTH)) begin
               for (int i = 0; i < DEPTH; i++)
                  if (CW'(i) == cnt_q) stk_q[i] <= push_lvl;
               cnt_q <= cnt_q + CW'(1);
            end else if (pop && cnt_q != '0) begin
               cnt_q <= cnt_q - CW'(1);
            end
         end

         assign full = (cnt_q == CW'(DEPTH));

         // R10: depth never exceeded
         p_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(DEPTH));
      end
   endgenerate

   // R5: a newly entered handler becomes the visible top tier
   p_push_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (top_lvl == $past(push_lvl)));

   // R9: ending a handler uncovers a strictly lower tier
   p_pop_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && top_lvl != LVL_NONE) |=> (top_lvl < $past(top_lvl)));

endmodule

// File: rtl/irq3_ctrl.sv
module irq3_ctrl
   import irq3_pkg::*;
#(
   parameter int N_SRC     = 15,
   parameter int N_VEC     = 10,
   parameter int N_TOPCAP  = 2,
   parameter int ADDR_W    = 8,
   parameter int VEC_BASE  = 3,
   parameter int VEC_STEP  = 8,
   parameter int ISR_DEPTH = 3,
   parameter int ISR_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req_i,
   input  logic [N_SRC-1:0]  src_en_i,
   input  logic [N_VEC-1:0]  lvl_hi_i,
   input  logic              eoh_i,
   output logic              irq_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic [N_SRC-1:0]  src_ack_o
);

   localparam int VIW      = (N_VEC > 1) ? $clog2(N_VEC) : 1;
   localparam int ADDR_TOP = VEC_BASE + (N_VEC - 1) * VEC_STEP;

   generate
      if (N_TOPCAP > N_VEC) begin : g_chk_cap
         $error("irq3_ctrl: N_TOPCAP exceeds N_VEC");
      end
      if (ADDR_TOP >= (1 << ADDR_W)) begin : g_chk_addr
         $error("irq3_ctrl: vector addresses do not fit ADDR_W");
      end
      if (ISR_DEPTH < 3) begin : g_chk_depth
         $error("irq3_ctrl: in-service record needs one slot per tier");
      end
   endgenerate

   logic [N_SRC-1:0]      pend;
   logic [N_SRC-1:0]      src_live;
   logic [N_VEC-1:0]      vec_pend;
   logic [N_VEC-1:0][1:0] vec_lvl;
   logic                  win_valid;
   logic [1:0]            win_lvl;
   logic [VIW-1:0]        win_idx;
   logic [N_SRC-1:0]      win_src_oh;
   logic [1:0]            isr_top;
   logic                  isr_full;
   logic                  issue;
   logic                  pop;
   logic [N_SRC-1:0]      ack_d;
   logic [ADDR_W-1:0]     addr_d;

   logic                  irq_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [N_SRC-1:0]      ack_q;

   assign src_live = pend & src_en_i;

   irq3_pend #(.N_SRC(N_SRC)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_req (src_req_i),
      .src_en  (src_en_i),
      .src_clr (ack_d),
      .pend_o  (pend)
   );

   irq3_vec_merge #(.N_SRC(N_SRC), .N_VEC(N_VEC), .N_TOPCAP(N_TOPCAP)) u_merge (
      .src_live (src_live),
      .lvl_hi   (lvl_hi_i),
      .vec_pend (vec_pend),
      .vec_lvl  (vec_lvl)
   );

   irq3_arb #(.N_SRC(N_SRC), .N_VEC(N_VEC), .VIW(VIW)) u_arb (
      .vec_pend   (vec_pend),
      .vec_lvl    (vec_lvl),
      .src_live   (src_live),
      .win_valid  (win_valid),
      .win_lvl    (win_lvl),
      .win_idx    (win_idx),
      .win_src_oh (win_src_oh)
   );

   // Issue only above the running tier, never in an end-of-handler cycle.
   assign issue  = win_valid && (win_lvl > isr_top) && !eoh_i && !isr_full;
   assign pop    = eoh_i && (isr_top != LVL_NONE);
   assign ack_d  = issue ? win_src_oh : '0;
   assign addr_d = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);

   irq3_isr_rec #(.DEPTH(ISR_DEPTH), .STYLE(ISR_STYLE)) u_isr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (issue),
      .push_lvl (win_lvl),
      .pop      (pop),
      .top_lvl  (isr_top),
      .full     (isr_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         addr_q <= '0;
         ack_q  <= '0;
      end else begin
         irq_q <= issue;
         ack_q <= ack_d;
         if (issue) addr_q <= addr_d;
      end
   end

   assign irq_o      = irq_q;
   assign vec_addr_o = addr_q;
   assign src_ack_o  = ack_q;

   // R7: at most one source acknowledged at a time
   p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_ack_o));

   // R7: acknowledge and interrupt pulse travel together
   p_irq_ack_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (src_ack_o != '0));

   // R2: issued address lies on the vector grid
   p_addr_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((vec_addr_o >= ADDR_W'(VEC_BASE)) && (vec_addr_o <= ADDR_W'(ADDR_TOP)) &&
                 (((vec_addr_o - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STEP)) == '0)));

   // R5: every issued interrupt raised the running tier
   p_nest_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (isr_top > $past(isr_top)));

   // R9: nothing issued right after an end-of-handler cycle
   p_eoh_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eoh_i |=> !irq_o);

endmodule

// File: tb/irq3_ctrl_tb.sv
`timescale 1ns/1ps
module irq3_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] src_req = '0;
   logic [14:0] src_en = '1;
   logic [9:0]  lvl_hi = '0;
   logic        eoh = 1'b0;
   logic        irq;
   logic [7:0]  vec_addr;
   logic [14:0] src_ack;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq3_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_req_i  (src_req),
      .src_en_i   (src_en),
      .lvl_hi_i   (lvl_hi),
      .eoh_i      (eoh),
      .irq_o      (irq),
      .vec_addr_o (vec_addr),
      .src_ack_o  (src_ack)
   );

   // {req[14:0], lvl_hi[9:0], winning vector[3:0], acked source[3:0]}
   localparam logic [32:0] TBL [11] = '{
      {15'h0020, 10'h000, 4'd5, 4'd5},
      {15'h0084, 10'h000, 4'd2, 4'd2},
      {15'h0084, 10'h080, 4'd7, 4'd7},
      {15'h0102, 10'h102, 4'd1, 4'd1},
      {15'h0C00, 10'h000, 4'd3, 4'd10},
      {15'h2200, 10'h000, 4'd6, 4'd13},
      {15'h4001, 10'h080, 4'd7, 4'd14},
      {15'h7FFF, 10'h000, 4'd0, 4'd0},
      {15'h7FFF, 10'h202, 4'd1, 4'd1},
      {15'h7FFF, 10'h220, 4'd5, 4'd5},
      {15'h0011, 10'h010, 4'd4, 4'd4}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic fire(logic [14:0] m);
      src_req = m;
      tick();
      src_req = '0;
   endtask

   task automatic eoh_pulse();
      eoh = 1'b1;
      tick();
      eoh = 1'b0;
   endtask

   task automatic expect_issue(string tag, int v, int s);
      chk({tag, " irq"}, 32'(irq), 32'd1);
      chk({tag, " addr"}, 32'(vec_addr), 32'(3 + 8 * v));
      chk({tag, " ack"}, 32'(src_ack), 32'(15'(1) << s));
   endtask

   task automatic cleanup();
      src_en = '0;
      tick();
      eoh_pulse();
      eoh_pulse();
      eoh_pulse();
      src_en = '1;
      lvl_hi = '0;
      tick();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [32:0] e;
      repeat (3) tick();
      // R1: reset state
      chk("R1 irq in reset", 32'(irq), 32'd0);
      rst_n = 1'b1;
      tick();
      tick();
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 ack", 32'(src_ack), 32'd0);
      chk("R1 addr", 32'(vec_addr), 32'd0);

      // R2 R3 R4 R6 table walk
      for (int i = 0; i < 11; i++) begin
         e = TBL[i];
         lvl_hi = e[17:8];
         fire(e[32:18]);
         tick();
         expect_issue($sformatf("R4 row %0d", i), int'(e[7:4]), int'(e[3:0]));
         cleanup();
         chk($sformatf("R2 quiet after row %0d", i), 32'(irq), 32'd0);
      end

      // R7 single-cycle pulse, R5 hold-off, R8 persistence
      fire(15'h0020);
      tick();
      expect_issue("R7 first", 5, 5);
      tick();
      chk("R7 irq one cycle", 32'(irq), 32'd0);
      chk("R7 ack one cycle", 32'(src_ack), 32'd0);
      fire(15'h0004);
      tick();
      tick();
      chk("R5 equal tier held", 32'(irq), 32'd0);
      eoh_pulse();
      tick();
      expect_issue("R8 held request served", 2, 2);
      cleanup();

      // R5 R10 R9 nesting and pop order
      lvl_hi = 10'h181;
      fire(15'h0200);
      tick();
      expect_issue("R5 low", 9, 9);
      fire(15'h0100);
      tick();
      expect_issue("R5 high nests", 8, 8);
      fire(15'h0001);
      tick();
      expect_issue("R10 top nests", 0, 0);
      lvl_hi = 10'h183;
      fire(15'h0002);
      tick();
      tick();
      chk("R10 second top held", 32'(irq), 32'd0);
      fire(15'h0080);
      tick();
      tick();
      chk("R5 high under top held", 32'(irq), 32'd0);
      eoh_pulse();
      tick();
      expect_issue("R9 pop top", 1, 1);
      eoh_pulse();
      tick();
      chk("R9 high still held", 32'(irq), 32'd0);
      eoh_pulse();
      tick();
      expect_issue("R9 pop high", 7, 7);
      cleanup();

      // R9 eoh blocks issue in its own cycle
      fire(15'h0010);
      tick();
      expect_issue("R9 setup", 4, 4);
      lvl_hi = 10'h020;
      src_req = 15'h0020;
      tick();
      src_req = '0;
      eoh = 1'b1;
      tick();
      eoh = 1'b0;
      chk("R9 blocked in eoh cycle", 32'(irq), 32'd0);
      tick();
      expect_issue("R9 issued after eoh", 5, 5);
      cleanup();

      // R8 enable clear discards, disabled request ignored
      fire(15'h0010);
      tick();
      expect_issue("R8 setup", 4, 4);
      fire(15'h0004);
      src_en[2] = 1'b0;
      tick();
      src_en[2] = 1'b1;
      eoh_pulse();
      tick();
      chk("R8 discarded by enable", 32'(irq), 32'd0);
      tick();
      chk("R8 discarded later", 32'(irq), 32'd0);
      src_en[6] = 1'b0;
      fire(15'h0040);
      src_en[6] = 1'b1;
      tick();
      tick();
      chk("R8 disabled request ignored", 32'(irq), 32'd0);
      cleanup();

      // R6 shared vector siblings
      fire(15'h0C00);
      tick();
      expect_issue("R6 first sibling", 3, 10);
      tick();
      chk("R6 sibling waits", 32'(irq), 32'd0);
      eoh_pulse();
      tick();
      expect_issue("R6 second sibling", 3, 11);
      cleanup();

      // R3 vector 2 upper tier is high, vector 1 upper tier is top
      lvl_hi = 10'h00C;
      fire(15'h0008);
      tick();
      expect_issue("R3 high vector 3", 3, 3);
      fire(15'h0004);
      tick();
      tick();
      chk("R3 vector 2 cannot reach top", 32'(irq), 32'd0);
      lvl_hi = 10'h00E;
      fire(15'h0002);
      tick();
      expect_issue("R3 vector 1 top nests", 1, 1);
      cleanup();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule